// File: doc/BRIEF.md
# Saturating Clear-On-Read Network Error Tallies

This block keeps three 8-bit statistics tallies for a network receiver. The tallies count frames with alignment errors, frames with CRC errors, and frames dropped for lack of buffer space. Each tally has its own event input. Every event is qualified by an address-match input, which pulses for a frame that passed address recognition. A monitor-mode input changes the meaning of the dropped-frames tally: in that mode it counts every address-matched frame.

Software reads a tally through a small read port. It gives an index and a one-cycle read strobe. The tally value appears on the registered read-data output one cycle later, and the tally clears at the same clock edge. A tally never goes above 192; further events leave it at that ceiling. An event that coincides with the clearing read of its own tally is kept, so the tally restarts at 1. A status flag is high while any tally holds 128 or more, which lets software drain the tallies before they saturate.

Each tally is a four-state machine:
- `CS_EMPTY`: value 0.
- `CS_LOW`: 1 to 127.
- `CS_HIGH`: 128 to 191.
- `CS_FULL`: 192.

The transitions are:
- `EMPTY->LOW`: on an event.
- `LOW->HIGH`: on an event at 127.
- `HIGH->FULL`: on an event at 191.
- Any state to `EMPTY`: on a read with no event.
- Any state to `LOW`: on a read with an event.
- All other cases hold the current state.

Top module: `err_tally_top`

## Requirements
- R1: After reset every tally is 0, `rd_data` is 0 and `half_flag` is 0.
- R2: A tally never exceeds 192. An event while a tally is at 192 leaves it at 192.
- R3: A read with `rd_en` high loads `rd_data` at the next clock edge with the value of the selected tally and clears that tally at the same edge. The index encoding is: 0 = alignment, 1 = CRC, 2 = dropped frames. Index 3 returns 0 and changes no tally.
- R4: The alignment tally increments by one in a cycle where `ev_align` and `addr_match` are both high, and in no other cycle.
- R5: The CRC tally increments by one in a cycle where `ev_crc` and `addr_match` are both high, and in no other cycle.
- R6: With `monitor_en` low, the dropped-frames tally increments in a cycle where `ev_nobuf` and `addr_match` are both high.
- R7: With `monitor_en` high, the dropped-frames tally increments in every cycle where `addr_match` is high, and `ev_nobuf` is ignored.
- R8: If an event and a clearing read hit the same tally in one cycle, `rd_data` shows the old value and the tally becomes 1.
- R9: `half_flag` is high exactly while at least one tally is 128 or more.
- R10: `rd_data` holds its value in cycles where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_align | input | 1 | Frame alignment error event |
| ev_crc | input | 1 | CRC error event |
| ev_nobuf | input | 1 | Frame dropped for lack of buffer space |
| addr_match | input | 1 | Frame passed address recognition |
| monitor_en | input | 1 | Monitor mode: dropped-frames tally counts matched frames |
| rd_en | input | 1 | Read strobe (clears the selected tally) |
| rd_sel | input | 2 | Tally index to read |
| rd_data | output | 8 | Registered read value |
| half_flag | output | 1 | Some tally is at 128 or more |

## Verification
A tally updates at the first clock edge after its event. `half_flag` follows combinationally from the tally state, so it is valid in that same cycle. `rd_data` is loaded at the edge that samples `rd_en`, so a read result is due exactly one cycle after the strobe. The bench drives its inputs on the falling edge and waits for one rising edge. It then compares `rd_data` and `half_flag` on the next falling edge against a reference model that it updates at that same rising edge.

// File: rtl/tally_pkg.sv
package tally_pkg;
    localparam int TALLY_N = 3;

    typedef enum logic [1:0] {
        CS_EMPTY,
        CS_LOW,
        CS_HIGH,
        CS_FULL
    } cnt_state_e;

    localparam int IDX_ALIGN = 0;
    localparam int IDX_CRC   = 1;
    localparam int IDX_LOST  = 2;
endpackage

// File: rtl/tally_event_qual.sv
module tally_event_qual
    import tally_pkg::*;
(
    input  logic               ev_align,
    input  logic               ev_crc,
    input  logic               ev_nobuf,
    input  logic               addr_match,
    input  logic               monitor_en,
    output logic [TALLY_N-1:0] inc
);
    always_comb begin
        inc            = '0;
        inc[IDX_ALIGN] = ev_align & addr_match;
        inc[IDX_CRC]   = ev_crc & addr_match;
        inc[IDX_LOST]  = monitor_en ? addr_match : (ev_nobuf & addr_match);
    end

    always_comb begin
        if (!addr_match) begin
            assert_qual_needs_match_R4: assert (inc == '0);
        end
        if (monitor_en) begin
            assert_monitor_counts_match_R7: assert (inc[IDX_LOST] == addr_match);
        end
    end
endmodule

// File: rtl/tally_cell.sv
module tally_cell
    import tally_pkg::*;
#(
    parameter int W    = 8,
    parameter int CEIL = 192
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count,
    output cnt_state_e   state
);
    localparam logic [W-1:0] CEIL_V  = CEIL[W-1:0];
    localparam logic [W-1:0] CEIL_M1 = CEIL_V - 1'b1;
    localparam logic [W-1:0] HALF_M1 = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONE_V   = {{(W-1){1'b0}}, 1'b1};

    cnt_state_e   st_nx;
    logic [W-1:0] cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CS_EMPTY;
            count <= '0;
        end else begin
            state <= st_nx;
            count <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = state;
        cnt_nx = count;
        unique case (state)
            CS_EMPTY: begin
                if (inc) begin
                    st_nx  = CS_LOW;
                    cnt_nx = ONE_V;
                end
            end
            CS_LOW: begin
                if (clr) begin
                    st_nx  = inc ? CS_LOW : CS_EMPTY;
                    cnt_nx = inc ? ONE_V : '0;
                end else if (inc) begin
                    cnt_nx = count + 1'b1;
                    if (count == HALF_M1) st_nx = CS_HIGH;
                end
            end
            CS_HIGH: begin
                if (clr) begin
                    st_nx  = inc ? CS_LOW : CS_EMPTY;
                    cnt_nx = inc ? ONE_V : '0;
                end else if (inc) begin
                    cnt_nx = count + 1'b1;
                    if (count == CEIL_M1) st_nx = CS_FULL;
                end
            end
            CS_FULL: begin
                if (clr) begin
                    st_nx  = inc ? CS_LOW : CS_EMPTY;
                    cnt_nx = inc ? ONE_V : '0;
                end
            end
            default: begin
                st_nx  = CS_EMPTY;
                cnt_nx = '0;
            end
        endcase
    end

    assert_ceiling_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CEIL_V);
    assert_sat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CEIL_V && !clr) |=> count == CEIL_V);
    assert_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> count == '0);
    assert_read_keep_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> count == ONE_V);
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count < CEIL_V) |=> count == $past(count) + 1'b1);
    assert_state_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CS_HIGH) || (state == CS_FULL)) == count[W-1]);
endmodule

// File: rtl/tally_read_port.sv
module tally_read_port
    import tally_pkg::*;
#(
    parameter int N = TALLY_N,
    parameter int W = 8,
    localparam int SEL_W = (N > 1) ? $clog2(N + 1) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [SEL_W-1:0]      rd_sel,
    input  logic [N-1:0][W-1:0]   counts,
    output logic [N-1:0]          clr,
    output logic [W-1:0]          rd_data
);
    logic [W-1:0] picked;

    always_comb begin
        picked = '0;
        clr    = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                picked = counts[i];
                clr[i] = rd_en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) rd_data <= picked;
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    assert_bad_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_sel) >= N) |=> rd_data == '0);
    assert_one_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));
endmodule

// File: rtl/err_tally_top.sv
module err_tally_top
    import tally_pkg::*;
#(
    parameter int W    = 8,
    parameter int CEIL = 192
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_align,
    input  logic         ev_crc,
    input  logic         ev_nobuf,
    input  logic         addr_match,
    input  logic         monitor_en,
    input  logic         rd_en,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    output logic         half_flag
);
    logic [TALLY_N-1:0]        inc;
    logic [TALLY_N-1:0]        clr;
    logic [TALLY_N-1:0][W-1:0] counts;
    logic [TALLY_N-1:0]        upper;
    cnt_state_e                states [TALLY_N];

    tally_event_qual u_qual (
        .ev_align   (ev_align),
        .ev_crc     (ev_crc),
        .ev_nobuf   (ev_nobuf),
        .addr_match (addr_match),
        .monitor_en (monitor_en),
        .inc        (inc)
    );

    for (genvar g = 0; g < TALLY_N; g++) begin : g_cell
        tally_cell #(.W(W), .CEIL(CEIL)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[g]),
            .clr   (clr[g]),
            .count (counts[g]),
            .state (states[g])
        );
        assign upper[g] = (states[g] == CS_HIGH) || (states[g] == CS_FULL);
    end

    tally_read_port #(.N(TALLY_N), .W(W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .counts  (counts),
        .clr     (clr),
        .rd_data (rd_data)
    );

    assign half_flag = |upper;

    assert_flag_needs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        half_flag |-> (counts[0][W-1] || counts[1][W-1] || counts[2][W-1]));
endmodule

// File: tb/err_tally_top_bench.sv
module err_tally_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_align = 0, ev_crc = 0, ev_nobuf = 0, addr_match = 0, monitor_en = 0;
    logic       rd_en = 0;
    logic [1:0] rd_sel = 0;
    logic [7:0] rd_data;
    logic       half_flag;

    int total = 0;
    int bad = 0;
    int exp_c [3];
    int exp_rd = 0;

    always #10 clk = ~clk;

    err_tally_top u_err_tally_top (
        .clk(clk), .rst_n(rst_n), .ev_align(ev_align), .ev_crc(ev_crc),
        .ev_nobuf(ev_nobuf), .addr_match(addr_match), .monitor_en(monitor_en),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .half_flag(half_flag)
    );

    function automatic int next_cnt(int cur, bit inc, bit clr);
        if (clr) return inc ? 1 : 0;
        if (inc) return (cur >= 192) ? 192 : cur + 1;
        return cur;
    endfunction

    function automatic bit any_high();
        for (int i = 0; i < 3; i++) if (exp_c[i] >= 128) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(string tag, bit a, bit c, bit n, bit m, bit mon, bit re, int sel);
        bit inc [3];
        ev_align = a; ev_crc = c; ev_nobuf = n; addr_match = m;
        monitor_en = mon; rd_en = re; rd_sel = sel[1:0];
        @(posedge clk);
        inc[0] = a & m;
        inc[1] = c & m;
        inc[2] = mon ? m : (n & m);
        if (re) exp_rd = (sel < 3) ? exp_c[sel] : 0;
        for (int i = 0; i < 3; i++) exp_c[i] = next_cnt(exp_c[i], inc[i], re && sel == i);
        @(negedge clk);
        chk(tag, int'(rd_data), exp_rd);
        chk("R9", int'(half_flag), int'(any_high()));
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 3; i++) exp_c[i] = 0;
        repeat (3) @(negedge clk);
        chk("R1", int'(rd_data), 0);
        chk("R1", int'(half_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 3; s++) step("R1", 0, 0, 0, 0, 0, 1, s);

        // R4: events without match are ignored
        repeat (5) step("R4", 1, 0, 0, 0, 0, 0, 0);
        step("R4", 0, 0, 0, 0, 0, 1, 0);
        repeat (7) step("R4", 1, 0, 0, 1, 0, 0, 0);
        step("R4", 0, 0, 0, 0, 0, 1, 0);
        chk("R4", int'(rd_data), 7);

        // R5
        repeat (4) step("R5", 0, 1, 0, 0, 0, 0, 0);
        repeat (6) step("R5", 0, 1, 0, 1, 0, 0, 0);
        step("R5", 0, 0, 0, 0, 0, 1, 1);
        chk("R5", int'(rd_data), 6);

        // R2: saturation at 192
        repeat (200) step("R2", 1, 0, 0, 1, 0, 0, 0);
        step("R2", 0, 0, 0, 0, 0, 1, 0);
        chk("R2", int'(rd_data), 192);
        chk("R9", int'(half_flag), 0);

        // R8: event and read together
        repeat (10) step("R8", 0, 1, 0, 1, 0, 0, 0);
        step("R8", 0, 1, 0, 1, 0, 1, 1);
        chk("R8", int'(rd_data), 10);
        step("R8", 0, 0, 0, 0, 0, 1, 1);
        chk("R8", int'(rd_data), 1);

        // R7: monitor mode counts matched frames, ignores ev_nobuf
        repeat (5) step("R7", 0, 0, 0, 1, 1, 0, 0);
        repeat (3) step("R7", 0, 0, 1, 0, 1, 0, 0);
        step("R7", 0, 0, 0, 0, 1, 1, 2);
        chk("R7", int'(rd_data), 5);

        // R6: normal mode counts dropped matched frames
        repeat (4) step("R6", 0, 0, 1, 1, 0, 0, 0);
        repeat (2) step("R6", 0, 0, 0, 1, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0, 1, 2);
        chk("R6", int'(rd_data), 4);

        // R3: index 3 returns zero, touches nothing
        repeat (3) step("R3", 1, 0, 0, 1, 0, 0, 0);
        step("R3", 0, 0, 0, 0, 0, 1, 3);
        chk("R3", int'(rd_data), 0);
        step("R3", 0, 0, 0, 0, 0, 1, 0);
        chk("R3", int'(rd_data), 3);

        // R10: hold without strobe
        repeat (4) step("R10", 1, 0, 0, 1, 0, 0, 0);
        chk("R10", int'(rd_data), 3);

        // random mix
        for (int k = 0; k < 4000; k++) begin
            step("R3", ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
                 ($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 40) == 0,
                 int'($urandom % 4));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule